// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block is the slave receiving end of a three-wire stereo audio link. The link has a bit clock, a frame clock that tells the two channels apart, and a serial data line. The bit clock is the block's only clock. On each rising bit-clock edge the block samples the frame clock and the data line. It rebuilds one 24-bit two's-complement word per channel. It presents each left/right pair together with a one-cycle strobe. The block never drives either clock.

A 3-bit format code selects how the words sit in the frame. The word can end at the frame-clock edge (right-justified, 16, 20 or 24 bits). It can start right at the frame-clock edge (left-justified, 24 bits). It can start one bit clock after the edge (I2S, 24 bits). Words narrower than 24 bits are left-aligned in the output, with zeros filling the low bits. So the surrounding logic always sees full-scale 24-bit samples, whatever the link format.

Top module: `audio_serial_rx`

## Requirements
- R1: Format code `fmt_sel` decodes as follows: 3'b000 is right-justified 16 bit, 3'b001 is right-justified 20 bit, 3'b010 is left-justified 24 bit, 3'b011 is I2S 24 bit and 3'b100 is right-justified 24 bit. The codes 3'b101 to 3'b111 decode as left-justified 24 bit.
- R2: While `rst_n` is low, both sample outputs are zero and `sample_valid` is low.
- R3: `lrclk` and `sdin` are sampled on the rising `bclk` edge. Words arrive MSB first and are passed through unchanged as two's complement, so 24'h800000 and 24'h7FFFFF arrive intact.
- R4: Code 3'b000 takes the 16 bits just before the frame-clock edge, placing them in output bits 23:8 with bits 7:0 zero. Earlier bits of that half-frame are ignored. It works with 16 and with 32 bit clocks per half-frame.
- R5: Code 3'b001 takes the 20 bits just before the frame-clock edge, placing them in bits 23:4 with bits 3:0 zero. Earlier bits are ignored. It works with 20 and with 32 bit clocks per half-frame.
- R6: Code 3'b100 takes the 24 bits just before the frame-clock edge, with 24 or 32 bit clocks per half-frame.
- R7: In left-justified mode the MSB is the bit sampled at the first rising edge that sees the new `lrclk` level. Bits after the 24th are ignored. When a half-frame is shorter than 24 bits, the missing low bits are zero.
- R8: In I2S mode the MSB is the bit sampled one bit clock after the first rising edge that sees the new `lrclk` level. With 24 bit clocks per half-frame, the LSB is the bit sampled in the first slot of the following half-frame.
- R9: In the left-justified and right-justified modes, `lrclk` high marks the left channel. In I2S mode, `lrclk` low marks the left channel.
- R10: `sample_valid` is a one-cycle pulse, raised once for each stereo frame whose left word and then right word were both received in full. It rises on the rising edge that sees the `lrclk` change ending the right half-frame. Both outputs update only on that edge and hold their values otherwise.
- R11: After reset, the half-frame in progress before the first observed `lrclk` change is discarded. A right word with no complete left word before it raises no pulse.
- R12: Every mode also works with 32 bit clocks per half-frame (64 per frame).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; sampling clock of the whole block |
| rst_n | input | 1 | Active-low reset |
| fmt_sel | input | 3 | Framing format code |
| lrclk | input | 1 | Frame clock selecting the channel |
| sdin | input | 1 | Serial audio data, MSB first |
| left_sample | output | 24 | Last complete left-channel word, left-aligned |
| right_sample | output | 24 | Last complete right-channel word, left-aligned |
| sample_valid | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
Every result is due exactly one register stage after the rising edge that first sees the frame clock change at the end of a right half-frame. Both channels and the strobe are visible after that edge and stay until the next such edge. The bench changes `lrclk` and `sdin` on falling edges. It pushes each pair's expected words when it finishes driving the left half. A monitor then compares the outputs on the falling edge that follows the pulse, so every check falls half a bit clock after the register update and clear of it. Once each stream's trailing half-frame has been driven, the expectation queue must be empty, which catches both missing and extra strobes.

// File: rtl/asrx_pkg.sv
`timescale 1ns/1ps
package asrx_pkg;

  localparam int SAMPLE_W = 24;

  typedef enum logic [2:0] {
    FMT_RJ16  = 3'b000,
    FMT_RJ20  = 3'b001,
    FMT_LJ24  = 3'b010,
    FMT_I2S24 = 3'b011,
    FMT_RJ24  = 3'b100
  } fmt_e;

  // Word ends at the frame-clock edge.
  function automatic logic is_rj(input logic [2:0] f);
    return (f == FMT_RJ16) || (f == FMT_RJ20) || (f == FMT_RJ24);
  endfunction

  // Significant bits carried by a right-justified format.
  function automatic int rj_bits(input logic [2:0] f);
    case (f)
      FMT_RJ16: return 16;
      FMT_RJ20: return 20;
      default:  return SAMPLE_W;
    endcase
  endfunction

  // Slots between the frame-clock edge and the MSB.
  function automatic int lead_slots(input logic [2:0] f);
    return (f == FMT_I2S24) ? 1 : 0;
  endfunction

  // Frame-clock level that marks the left channel.
  function automatic logic left_level(input logic [2:0] f);
    return (f == FMT_I2S24) ? 1'b0 : 1'b1;
  endfunction

  // Move the low rj_bits of the shift history to the top of the word.
  function automatic logic [SAMPLE_W-1:0] align_rj(input logic [SAMPLE_W-1:0] hist,
                                                   input logic [2:0] f);
    return hist << (SAMPLE_W - rj_bits(f));
  endfunction

endpackage

// File: rtl/asrx_lr_track.sv
`timescale 1ns/1ps
module asrx_lr_track (
  input  logic clk,
  input  logic rst_n,
  input  logic lrclk,
  output logic lr_prev,
  output logic half_end,
  output logic half_full
);
  logic primed;
  logic synced;

  // A change against the previous sample closes a half-frame; the first
  // sample after reset only seeds the history.
  assign half_end  = primed && (lrclk != lr_prev);
  assign half_full = half_end && synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      lr_prev <= 1'b0;
      synced  <= 1'b0;
    end else begin
      primed  <= 1'b1;
      lr_prev <= lrclk;
      if (half_end) synced <= 1'b1;
    end
  end
endmodule

// File: rtl/asrx_slot_count.sv
`timescale 1ns/1ps
module asrx_slot_count #(
  parameter int SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_end,
  output logic [SLOT_W-1:0] slot_cur,
  output logic [SLOT_W-1:0] slot_last
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  // Index of the bit sampled now within its half-frame, saturating.
  always_comb begin
    if (half_end)                   slot_cur = '0;
    else if (slot_last == SLOT_MAX) slot_cur = SLOT_MAX;
    else                            slot_cur = slot_last + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_last <= '0;
    else        slot_last <= slot_cur;
  end
endmodule

// File: rtl/asrx_word_cap.sv
`timescale 1ns/1ps
module asrx_word_cap
  import asrx_pkg::*;
#(
  parameter int SLOT_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sdin,
  input  logic [2:0]          fmt,
  input  logic                half_end,
  input  logic [SLOT_W-1:0]   slot_cur,
  input  logic [SLOT_W-1:0]   slot_last,
  output logic [SAMPLE_W-1:0] word
);
  localparam int IW = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] rj_hist;   // last SAMPLE_W bits, newest at bit 0
  logic [SAMPLE_W-1:0] fwd_word;  // word built from the edge forward
  logic [SAMPLE_W-1:0] fwd_next;
  logic [SAMPLE_W-1:0] fwd_done;
  logic [IW-1:0]       bit_sel;
  logic                in_window;
  logic                tail_slot;
  int                  pos;

  always_comb begin
    pos       = int'(slot_cur) - lead_slots(fmt);
    in_window = (pos >= 0) && (pos < SAMPLE_W);
    bit_sel   = IW'(SAMPLE_W - 1 - pos);
    fwd_next  = half_end ? '0 : fwd_word;
    if (in_window) fwd_next[bit_sel] = sdin;
  end

  // With a delayed MSB and a half-frame exactly SAMPLE_W slots long, the
  // LSB is the bit sampled on the closing edge itself.
  assign tail_slot = (lead_slots(fmt) == 1) && (int'(slot_last) == SAMPLE_W - 1);

  always_comb begin
    fwd_done = fwd_word;
    if (tail_slot) fwd_done[0] = sdin;
  end

  assign word = is_rj(fmt) ? align_rj(rj_hist, fmt) : fwd_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rj_hist  <= '0;
      fwd_word <= '0;
    end else begin
      rj_hist  <= {rj_hist[SAMPLE_W-2:0], sdin};
      fwd_word <= fwd_next;
    end
  end
endmodule

// File: rtl/asrx_pair_out.sv
`timescale 1ns/1ps
module asrx_pair_out
  import asrx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          fmt,
  input  logic                half_full,
  input  logic                lr_prev,
  input  logic [SAMPLE_W-1:0] word,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                sample_valid
);
  logic [SAMPLE_W-1:0] left_hold;
  logic                have_left;
  logic                closes_left;

  assign closes_left = (lr_prev == left_level(fmt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold    <= '0;
      have_left    <= 1'b0;
      left_sample  <= '0;
      right_sample <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (half_full) begin
        if (closes_left) begin
          left_hold <= word;
          have_left <= 1'b1;
        end else begin
          have_left <= 1'b0;
          if (have_left) begin
            left_sample  <= left_hold;
            right_sample <= word;
            sample_valid <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
`timescale 1ns/1ps
module audio_serial_rx
  import asrx_pkg::*;
#(
  parameter int SLOT_W = 7
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic [2:0]          fmt_sel,
  input  logic                lrclk,
  input  logic                sdin,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                sample_valid
);
  logic                lr_prev;
  logic                half_end;
  logic                half_full;
  logic [SLOT_W-1:0]   slot_cur;
  logic [SLOT_W-1:0]   slot_last;
  logic [SAMPLE_W-1:0] word;

  asrx_lr_track u_track (
    .clk       (bclk),
    .rst_n     (rst_n),
    .lrclk     (lrclk),
    .lr_prev   (lr_prev),
    .half_end  (half_end),
    .half_full (half_full)
  );

  asrx_slot_count #(.SLOT_W(SLOT_W)) u_slot (
    .clk       (bclk),
    .rst_n     (rst_n),
    .half_end  (half_end),
    .slot_cur  (slot_cur),
    .slot_last (slot_last)
  );

  asrx_word_cap #(.SLOT_W(SLOT_W)) u_cap (
    .clk       (bclk),
    .rst_n     (rst_n),
    .sdin      (sdin),
    .fmt       (fmt_sel),
    .half_end  (half_end),
    .slot_cur  (slot_cur),
    .slot_last (slot_last),
    .word      (word)
  );

  asrx_pair_out u_pair (
    .clk          (bclk),
    .rst_n        (rst_n),
    .fmt          (fmt_sel),
    .half_full    (half_full),
    .lr_prev      (lr_prev),
    .word         (word),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .sample_valid (sample_valid)
  );
endmodule

// File: rtl/asrx_checks.sv
`timescale 1ns/1ps
module asrx_checks (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  fmt_sel,
  input logic        half_end,
  input logic        half_full,
  input logic [23:0] left_sample,
  input logic [23:0] right_sample,
  input logic        sample_valid
);
  // R10: strobe lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  // R10: strobe only follows a complete half-frame boundary
  a_r10_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(half_full));

  // R10: outputs hold between strobes
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> ($stable(left_sample) && $stable(right_sample)));

  // R4: 16-bit words leave the low byte clear
  a_r4_pad16: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && fmt_sel == 3'b000 && $stable(fmt_sel)) |-> (right_sample[7:0] == 8'h00));

  // R5: 20-bit words leave the low nibble clear
  a_r5_pad20: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && fmt_sel == 3'b001 && $stable(fmt_sel)) |-> (right_sample[3:0] == 4'h0));

  // R11: a boundary before synchronisation yields no strobe
  a_r11_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (half_end && !half_full) |=> !sample_valid);
endmodule

bind audio_serial_rx asrx_checks u_checks (
  .clk          (bclk),
  .rst_n        (rst_n),
  .fmt_sel      (fmt_sel),
  .half_end     (half_end),
  .half_full    (half_full),
  .left_sample  (left_sample),
  .right_sample (right_sample),
  .sample_valid (sample_valid)
);

// File: tb/audio_serial_rx_test.sv
`timescale 1ns/1ps
module audio_serial_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lrclk = 1'b0;
  logic        sdin = 1'b0;
  logic [2:0]  fmt_sel = 3'b010;
  logic [23:0] left_sample;
  logic [23:0] right_sample;
  logic        sample_valid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [23:0] q_l[$];
  logic [23:0] q_r[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  audio_serial_rx uut (
    .bclk (clk), .rst_n (rst_n), .fmt_sel (fmt_sel), .lrclk (lrclk), .sdin (sdin),
    .left_sample (left_sample), .right_sample (right_sample), .sample_valid (sample_valid)
  );

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  function automatic logic left_lvl(input logic [2:0] f);
    return (f == 3'b011) ? 1'b0 : 1'b1;
  endfunction

  function automatic int kept_bits(input logic [2:0] f, input int h);
    case (f)
      3'b000:  return 16;
      3'b001:  return 20;
      3'b011:  return 24;
      3'b100:  return 24;
      default: return (h < 24) ? h : 24;
    endcase
  endfunction

  function automatic logic [23:0] expect_word(input logic [2:0] f, input int h, input logic [23:0] w);
    logic [23:0] m;
    m = 24'hFFFFFF;
    m = m << (24 - kept_bits(f, h));
    return w & m;
  endfunction

  // Bit on the line in slot s of a half-frame of h slots.
  function automatic logic slot_bit(input logic [2:0] f, input int h, input int s,
                                    input logic [23:0] w, input logic [23:0] prevw);
    int n;
    int p;
    case (f)
      3'b000, 3'b001, 3'b100: begin
        n = kept_bits(f, h);
        if (s < h - n) return 1'b1;
        return w[23 - (s - (h - n))];
      end
      3'b011: begin
        if (s == 0) return (h == 24) ? prevw[0] : 1'b1;
        p = s - 1;
        if (p < 24) return w[23 - p];
        return 1'b1;
      end
      default: begin
        if (s < 24) return w[23 - s];
        return 1'b1;
      end
    endcase
  endfunction

  function automatic logic [23:0] gen(input int seed, input int k);
    logic [31:0] x;
    if (k == 0) return 24'h800000;
    if (k == 1) return 24'h7FFFFF;
    x = 32'(seed) * 32'd7919 + 32'(k) * 32'd104729 + 32'h1234567;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x[23:0];
  endfunction

  task automatic drive_half(input logic [2:0] f, input int h, input logic lvl,
                            input logic [23:0] w, input logic [23:0] prevw);
    for (int s = 0; s < h; s++) begin
      @(negedge clk);
      lrclk = lvl;
      sdin  = slot_bit(f, h, s, w, prevw);
    end
  endtask

  task automatic run_case(input logic [2:0] f, input int h, input int n, input int seed,
                          input bit lead_left, input string tag);
    logic        lvl;
    logic [23:0] prev;
    logic [23:0] wl;
    logic [23:0] wr;
    lvl = left_lvl(f);
    @(negedge clk);
    rst_n   = 1'b0;
    fmt_sel = f;
    lrclk   = lead_left ? lvl : ~lvl;
    sdin    = 1'b0;
    repeat (3) @(negedge clk);
    check({"R2 reset left ", tag}, left_sample, 24'h0);
    check({"R2 reset right ", tag}, right_sample, 24'h0);
    check({"R2 reset strobe ", tag}, {23'h0, sample_valid}, 24'h0);
    rst_n = 1'b1;
    // R11: partial half-frame first, then maybe an orphan right half
    drive_half(f, 5, lead_left ? lvl : ~lvl, 24'h5A5A5A, 24'h0);
    prev = 24'h5A5A5A;
    if (lead_left) begin
      drive_half(f, h, ~lvl, 24'h123456, prev);
      prev = 24'h123456;
    end
    for (int i = 0; i < n; i++) begin
      wl = gen(seed, 2 * i);
      wr = gen(seed, 2 * i + 1);
      drive_half(f, h, lvl, wl, prev);
      prev = wl;
      q_l.push_back(expect_word(f, h, wl));
      q_r.push_back(expect_word(f, h, wr));
      q_tag.push_back(tag);
      drive_half(f, h, ~lvl, wr, prev);
      prev = wr;
    end
    drive_half(f, h, lvl, 24'h0, prev);
    repeat (4) @(negedge clk);
    checks++;
    if (q_l.size() != 0) begin
      errors++;
      $display("FAIL R10 %s missing strobes actual=%0d pending expected=0", tag, q_l.size());
      q_l.delete();
      q_r.delete();
      q_tag.delete();
    end
  endtask

  // Monitor: compare each strobed pair against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && sample_valid) begin
      if (q_l.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R10 unexpected strobe actual=1 expected=0");
      end else begin
        string t;
        t = q_tag.pop_front();
        check({"R9 R10 left ", t}, left_sample, q_l.pop_front());
        check({"R9 R10 right ", t}, right_sample, q_r.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    run_case(3'b010, 32, 4, 1, 1'b0, "R1 R3 R7 R12 lj 64fs");
    run_case(3'b010, 24, 3, 2, 1'b0, "R7 lj 48fs");
    run_case(3'b010, 16, 3, 3, 1'b0, "R7 lj short zero fill");
    run_case(3'b011, 32, 4, 4, 1'b0, "R1 R8 R12 i2s 64fs");
    run_case(3'b011, 24, 4, 5, 1'b0, "R8 i2s 48fs lsb spill");
    run_case(3'b000, 16, 3, 6, 1'b0, "R1 R4 rj16 32fs");
    run_case(3'b000, 32, 3, 7, 1'b0, "R4 R12 rj16 64fs");
    run_case(3'b001, 20, 3, 8, 1'b0, "R1 R5 rj20 40fs");
    run_case(3'b001, 32, 3, 9, 1'b0, "R5 R12 rj20 64fs");
    run_case(3'b100, 24, 3, 10, 1'b0, "R1 R6 rj24 48fs");
    run_case(3'b100, 32, 3, 11, 1'b0, "R6 R12 rj24 64fs");
    run_case(3'b111, 32, 2, 12, 1'b0, "R1 reserved code");
    run_case(3'b010, 32, 3, 13, 1'b1, "R11 lj leading partial");
    run_case(3'b011, 32, 3, 14, 1'b1, "R11 i2s leading partial");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule